// File: doc/BRIEF.md
# Stuck-Low Bus Recovery Sequencer

This block watches the two lines of a two-wire serial bus segment (clock and data) for a fault where one of them is held low far longer than any legal transfer allows. A separate timeout counter runs for each line. When either counter expires, the block asks the segment connection gate to open. It then runs a recovery routine: a settling wait, a burst of clock pulses that lets a stuck target finish its byte and let go of data, and a closing STOP condition.

The block drives no pad itself. It produces active-high pull-down enables (1 = pull the line low, 0 = release it) for the clock and data lines, a disconnect request (1 = open the gate) and a busy flag. It senses the resolved line levels on `scl_in` and `sda_in`. Every time constant is a parameter counted in system clock cycles. A rising edge on `enable` restarts both timers and drops the disconnect request, even while a line is still stuck.

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `busy`, `disconnect`, `scl_pull` and `sda_pull` are all 0.
- R2: Each line has its own timer that counts clock cycles in which the line is sampled low. A single cycle sampled high restarts that timer from zero. A line sampled low on TIMEOUT_CYC consecutive edges raises `busy` and `disconnect` at the last of those edges.
- R3: On a timeout, `busy` and `disconnect` both go to 1 in the same cycle and stay at 1 for the whole recovery sequence.
- R4: For SETTLE_CYC cycles after `busy` rises, neither pull-down is asserted. No pull-down is ever asserted while `busy` is 0.
- R5: Each recovery clock pulse is HALF_CYC cycles with `scl_pull`=1, followed by HALF_CYC cycles with it released. At most MAX_PULSES pulses are driven.
- R6: The bus counts as recovered when both `scl_in` and `sda_in` read 1. This is checked at the last cycle of the settling wait and at the last cycle of each released half-period. If the bus has recovered, no further pulse is started, so zero pulses are driven when the bus is free at the end of the settling wait.
- R7: Every sequence ends with a STOP, whether or not the bus recovered. The STOP has three phases of HALF_CYC cycles each: first both pulls at 1, then `scl_pull`=0 with `sda_pull`=1, then both released. `busy` returns to 0 on the cycle after the last phase.
- R8: When `busy` falls, `disconnect` stays at 1 if the bus is not recovered at the last STOP cycle. If the bus is recovered, `disconnect` goes to 0.
- R9: A rising edge of `enable` clears `disconnect` on the next cycle and restarts both timers from zero. A line that is still stuck therefore times out again only after a further TIMEOUT_CYC cycles.
- R10: A line held low without a break produces only one timeout. Once a sequence has finished, no new one starts until that line goes high or `enable` rises. Timeouts that occur while `busy` is 1 do not restart or change the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sensed level of the clock line on the watched segment |
| sda_in | input | 1 | Sensed level of the data line on the watched segment |
| enable | input | 1 | A rising edge restarts the timers and clears the disconnect request |
| scl_pull | output | 1 | 1 = pull the clock line low |
| sda_pull | output | 1 | 1 = pull the data line low |
| disconnect | output | 1 | 1 = request that the segment gate open |
| busy | output | 1 | 1 from a timeout until the STOP has finished |

## Verification
The bench builds the block with TIMEOUT_CYC=20, SETTLE_CYC=6, HALF_CYC=3 and MAX_PULSES=16. Short windows like these make every cycle of a sequence cheap to compare, including a full 16-pulse burst that reaches the pulse cap. The short timeout also makes room for a timer-restart glitch one cycle before expiry, a data target that lets go after three or five clock rises, and a clock line freed during the settling wait. A small timeout also lets the bench watch more than TIMEOUT_CYC idle cycles after a failed recovery. This shows that a line stuck without a break never triggers a second sequence until `enable` rises.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_SETTLE,
      RS_CLK_LOW,
      RS_CLK_HIGH,
      RS_STOP_LOW,
      RS_STOP_SETUP,
      RS_STOP_REL
   } rcv_state_t;

   localparam int LINE_COUNT = 2;
   localparam int LINE_SCL   = 0;
   localparam int LINE_SDA   = 1;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/brs_line_timer.sv
module brs_line_timer #(
   parameter int TIMEOUT_CYC = 3000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic clear_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("brs_line_timer: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             line_low;

   assign line_low = ~line_in;
   assign expire_o = line_low & ~clear_i & (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || !line_low) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_SAT) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      line_in |=> (cnt_q == '0)); // R2

   AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o); // R10

endmodule

// File: rtl/brs_recovery_fsm.sv
module brs_recovery_fsm
   import bus_recovery_pkg::*;
#(
   parameter int SETTLE_CYC = 4000,
   parameter int HALF_CYC   = 5882,
   parameter int MAX_PULSES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_any_i,
   input  logic scl_in,
   input  logic sda_in,
   input  logic enable,
   output logic en_rise_o,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic disconnect_o,
   output logic busy_o
);
   localparam int TMR_W = $clog2(max_of(SETTLE_CYC, HALF_CYC) + 1);
   localparam int PC_W  = $clog2(MAX_PULSES + 1);
   localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
   localparam logic [TMR_W-1:0] HALF_LAST   = TMR_W'(HALF_CYC - 1);
   localparam logic [PC_W-1:0]  PULSE_LAST  = PC_W'(MAX_PULSES - 1);
   localparam logic [PC_W-1:0]  PULSE_CAP   = PC_W'(MAX_PULSES);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("brs_recovery_fsm: SETTLE_CYC must be at least 1");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("brs_recovery_fsm: HALF_CYC must be at least 1");
      end
      if (MAX_PULSES < 1 || MAX_PULSES > 255) begin : g_bad_pulses
         $error("brs_recovery_fsm: MAX_PULSES must be in 1..255");
      end
   endgenerate

   rcv_state_t       state_q;
   logic [TMR_W-1:0] tmr_q;
   logic [PC_W-1:0]  pulse_q;
   logic             disc_q;
   logic             en_q;
   logic             bus_free;
   logic             phase_done;

   assign bus_free   = scl_in & sda_in;
   assign en_rise_o  = enable & ~en_q;
   assign phase_done = (state_q == RS_SETTLE) ? (tmr_q == SETTLE_LAST)
                                              : (tmr_q == HALF_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         tmr_q   <= '0;
         pulse_q <= '0;
         disc_q  <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         en_q <= enable;
         if (en_rise_o) begin
            disc_q <= 1'b0;
         end
         if (state_q != RS_IDLE) begin
            tmr_q <= phase_done ? '0 : tmr_q + TMR_W'(1);
         end
         unique case (state_q)
            RS_IDLE: begin
               if (expire_any_i) begin
                  state_q <= RS_SETTLE;
                  tmr_q   <= '0;
                  pulse_q <= '0;
                  disc_q  <= 1'b1;
               end
            end
            RS_SETTLE: begin
               if (phase_done) begin
                  state_q <= bus_free ? RS_STOP_LOW : RS_CLK_LOW;
               end
            end
            RS_CLK_LOW: begin
               if (phase_done) begin
                  state_q <= RS_CLK_HIGH;
               end
            end
            RS_CLK_HIGH: begin
               if (phase_done) begin
                  pulse_q <= pulse_q + PC_W'(1);
                  if (bus_free || pulse_q == PULSE_LAST) begin
                     state_q <= RS_STOP_LOW;
                  end else begin
                     state_q <= RS_CLK_LOW;
                  end
               end
            end
            RS_STOP_LOW: begin
               if (phase_done) begin
                  state_q <= RS_STOP_SETUP;
               end
            end
            RS_STOP_SETUP: begin
               if (phase_done) begin
                  state_q <= RS_STOP_REL;
               end
            end
            RS_STOP_REL: begin
               if (phase_done) begin
                  state_q <= RS_IDLE;
                  disc_q  <= ~bus_free;
               end
            end
            default: begin
               state_q <= RS_IDLE;
            end
         endcase
      end
   end

   assign busy_o       = (state_q != RS_IDLE);
   assign disconnect_o = disc_q;
   assign scl_pull_o   = (state_q == RS_CLK_LOW) || (state_q == RS_STOP_LOW);
   assign sda_pull_o   = (state_q == RS_STOP_LOW) || (state_q == RS_STOP_SETUP);

   AST_TIMEOUT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && expire_any_i) |=> (busy_o && disconnect_o)); // R3

   AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !en_rise_o) |=> (disconnect_o || !busy_o)); // R3

   AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q <= PULSE_CAP)); // R5

   AST_ENABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rise_o && !busy_o && !expire_any_i) |=> !disconnect_o); // R9

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
   import bus_recovery_pkg::*;
#(
   parameter int TIMEOUT_CYC = 3000000,
   parameter int SETTLE_CYC  = 4000,
   parameter int HALF_CYC    = 5882,
   parameter int MAX_PULSES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic enable,
   output logic scl_pull,
   output logic sda_pull,
   output logic disconnect,
   output logic busy
);
   generate
      if (HALF_CYC >= TIMEOUT_CYC) begin : g_bad_ratio
         $error("bus_recovery_seq: HALF_CYC must be shorter than TIMEOUT_CYC");
      end
   endgenerate

   logic [LINE_COUNT-1:0] line_lvl;
   logic [LINE_COUNT-1:0] expire;
   logic                  en_rise;

   assign line_lvl[LINE_SCL] = scl_in;
   assign line_lvl[LINE_SDA] = sda_in;

   for (genvar g = 0; g < LINE_COUNT; g++) begin : g_timer
      brs_line_timer #(
         .TIMEOUT_CYC(TIMEOUT_CYC)
      ) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (line_lvl[g]),
         .clear_i (en_rise),
         .expire_o(expire[g])
      );
   end

   brs_recovery_fsm #(
      .SETTLE_CYC(SETTLE_CYC),
      .HALF_CYC  (HALF_CYC),
      .MAX_PULSES(MAX_PULSES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .expire_any_i(|expire),
      .scl_in      (scl_in),
      .sda_in      (sda_in),
      .enable      (enable),
      .en_rise_o   (en_rise),
      .scl_pull_o  (scl_pull),
      .sda_pull_o  (sda_pull),
      .disconnect_o(disconnect),
      .busy_o      (busy)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(scl_pull || sda_pull)); // R4

endmodule

// File: tb/bus_recovery_seq_bench.sv
module bus_recovery_seq_bench;
   localparam int T_TO  = 20;
   localparam int T_ST  = 6;
   localparam int T_HF  = 3;
   localparam int N_MAX = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic scl_hold = 1'b0;
   logic sda_req = 1'b0;
   int   sda_base = 0;
   int   sda_target = 0;
   int   rise_cnt = 0;
   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   logic scl_pull, sda_pull, disconnect, busy;
   logic sda_hold;
   wire  scl_bus = ~(scl_pull | scl_hold);
   wire  sda_bus = ~(sda_pull | sda_hold);

   assign sda_hold = sda_req && ((rise_cnt - sda_base) < sda_target);

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   bus_recovery_seq #(
      .TIMEOUT_CYC(T_TO),
      .SETTLE_CYC (T_ST),
      .HALF_CYC   (T_HF),
      .MAX_PULSES (N_MAX)
   ) u_bus_recovery_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_bus),
      .sda_in    (sda_bus),
      .enable    (enable),
      .scl_pull  (scl_pull),
      .sda_pull  (sda_pull),
      .disconnect(disconnect),
      .busy      (busy)
   );

   // target model: counts clock rises seen on the resolved line
   always @(posedge scl_bus) rise_cnt <= rise_cnt + 1;

   // monitor: one expected {busy, disconnect, scl_pull, sda_pull} per cycle
   always @(negedge clk) begin : mon
      logic [3:0] e;
      logic [3:0] a;
      string      t;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {busy, disconnect, scl_pull, sda_pull};
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: {busy,disc,scl_pull,sda_pull} got %b expected %b", t, a, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic push(input logic [3:0] v, input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(v);
         tag_q.push_back(tag);
      end
   endtask

   task automatic push_recovery(input int npulses, input logic fin_disc);
      push(4'b1100, "R3", 1);
      push(4'b1100, "R4", T_ST - 1);
      for (int p = 0; p < npulses; p++) begin
         push(4'b1110, "R5", T_HF);
         push(4'b1100, (p == npulses - 1 && npulses < N_MAX) ? "R6" : "R5", T_HF);
      end
      push(4'b1111, "R7", T_HF);
      push(4'b1101, "R7", T_HF);
      push(4'b1100, "R7", T_HF);
      push({1'b0, fin_disc, 2'b00}, "R8", 1);
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
      @(negedge clk);
      #1;
   endtask

   initial begin
      // R1: state during and just after reset
      @(negedge clk); #1;
      push(4'b0000, "R1", 3);
      drain();
      rst_n = 1'b1;
      push(4'b0000, "R1", 3);
      drain();

      // R2 glitch one cycle before expiry, R6 clock line freed during settle
      scl_hold = 1'b1;
      push(4'b0000, "R2", 2 * T_TO - 1);
      push_recovery(0, 1'b0);
      repeat (T_TO - 1) @(negedge clk);
      #1 scl_hold = 1'b0;
      @(negedge clk);
      #1 scl_hold = 1'b1;
      repeat (T_TO + 2) @(negedge clk);
      #1 scl_hold = 1'b0;
      drain();
      push(4'b0000, "R8", 4);
      drain();

      // R6: data target lets go after three rises
      sda_base = rise_cnt;
      sda_target = 3;
      sda_req = 1'b1;
      push(4'b0000, "R2", T_TO - 1);
      push_recovery(3, 1'b0);
      drain();
      sda_req = 1'b0;
      push(4'b0000, "R8", 4);
      drain();

      // R5 full burst, R8 disconnect held, R10 no retrigger
      sda_base = rise_cnt;
      sda_target = 1000;
      sda_req = 1'b1;
      push(4'b0000, "R2", T_TO - 1);
      push_recovery(N_MAX, 1'b1);
      push(4'b0100, "R10", 2 * T_TO);
      drain();

      // R9: enable rise clears disconnect and restarts timing
      enable = 1'b1;
      sda_base = rise_cnt;
      sda_target = 5;
      push(4'b0000, "R9", T_TO);
      push_recovery(5, 1'b0);
      drain();
      enable = 1'b0;
      sda_req = 1'b0;
      push(4'b0000, "R9", 4);
      drain();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule